// File: doc/BRIEF.md
# Next Program Counter Unit

This unit picks the program counter value that an 8-bit processor fetches from next. Each cycle it takes the current opcode and the sequential program counter, meaning the address just past the whole current instruction. It also takes the operands the fetch stage has already gathered: an 8-bit operand byte and a 16-bit operand word. The remaining inputs are the accumulator, the data pointer, four status flags, the register tested by a loop or compare instruction, and the compare immediate.

From these it produces three registered outputs: the next program counter, a branch-taken indication, and a call marker. The call marker tells the surrounding core to push the sequential address as a return address.

Paged jumps and paged calls keep the upper five bits of the sequential counter. Below them sit the low three bits of the opcode, and below those sits the operand byte. Relative branches add the sign-extended operand byte to the sequential counter. Conditional branches that are not taken continue at the sequential counter. Stack memory traffic, register write-back, returns and fetch sequencing are handled elsewhere.

Top module: `npc_unit`

## Requirements
- R1: While rst_n is low, next_pc is 0x0000 and taken and is_call are 0.
- R2: The outputs present the result for the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R3: Opcodes 0xC0 to 0xC7 jump to {pc_seq[15:11], opcode[2:0], op_byte}, with taken 1 and is_call 0.
- R4: Opcodes 0xC8 to 0xCF form the target exactly as in R3, with taken 1 and is_call 1.
- R5: Opcode 0xD8 jumps to op_word. Opcode 0xD9 also jumps to op_word and sets is_call. Both set taken.
- R6: Opcode 0xDC always jumps to pc_seq plus op_byte sign-extended to 16 bits, modulo 2^16.
- R7: Opcode 0xDD jumps to dptr plus the zero-extended acc, modulo 2^16. Opcode 0xDE jumps to dptr. Both set taken.
- R8: Opcodes 0xE0 to 0xE7 take the relative target of R6 when their condition holds. The conditions in opcode order are: Z, not Z, C, not C, P, not P, S, not S. The flag bits are: flags[0] carry C, flags[1] zero Z, flags[2] odd parity P, flags[3] sign S.
- R9: Opcodes 0xD0 to 0xD3 take the relative target when (test_reg - 1) mod 256 is nonzero. A test_reg of 0x01 falls through, and a test_reg of 0x00 branches.
- R10: Opcodes 0xD4 to 0xD7 take the relative target when test_reg differs from cmp_imm. Opcode 0xDF takes it when acc differs from cmp_imm.
- R11: A conditional branch that is not taken gives next_pc = pc_seq with taken 0. Every opcode not listed in R3 to R10 gives pc_seq with taken 0 and is_call 0.
- R12: is_call is 1 only for 0xC8 to 0xCF and 0xD9, and is never 1 while taken is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 8 | Current instruction opcode |
| pc_seq | input | 16 | Address following the current instruction |
| op_byte | input | 8 | Operand byte: relative offset or page offset |
| op_word | input | 16 | Operand word: absolute target |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| flags | input | 4 | Status flags {S, P, Z, C} |
| test_reg | input | 8 | Register tested by loop or compare opcodes |
| cmp_imm | input | 8 | Compare immediate byte |
| next_pc | output | 16 | Registered next program counter |
| taken | output | 1 | Registered branch-taken indication |
| is_call | output | 1 | Registered call marker |

## Verification
The embedded properties take for granted that the inputs are stable and known at every rising edge after reset. They also assume that pc_seq, opcode and test_reg in one cycle describe a single instruction, so that the values recovered with $past belong together. The stimulus changes every input only on the falling edge and drives all of them to defined values from time zero. It walks all 256 opcodes under several operand patterns, some of which force compare equality. It then sweeps every flag combination for the flag branches and every test_reg value for the loop branch, so the one-valued and zero-valued loop registers and both compare outcomes are all reached.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int PC_W     = 16;
    localparam int DW       = 8;
    localparam int OP_W     = 8;
    localparam int FLAG_W   = 4;
    localparam int SEL_W    = 3;
    localparam int PAGE_LSB = DW + SEL_W;

    localparam int FL_CY = 0;
    localparam int FL_Z  = 1;
    localparam int FL_P  = 2;
    localparam int FL_S  = 3;

    typedef enum logic [3:0] {
        K_SEQ,
        K_PAGE_JMP,
        K_PAGE_CALL,
        K_LONG_JMP,
        K_LONG_CALL,
        K_REL,
        K_IDX,
        K_IND,
        K_FLAG,
        K_LOOP,
        K_CMP_REG,
        K_CMP_ACC
    } kind_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            taken;
        logic            call;
    } npc_out_t;

    function automatic kind_e classify(input logic [OP_W-1:0] op);
        kind_e k;
        casez (op)
            8'b11000???: k = K_PAGE_JMP;
            8'b11001???: k = K_PAGE_CALL;
            8'b110100??: k = K_LOOP;
            8'b110101??: k = K_CMP_REG;
            8'hD8:       k = K_LONG_JMP;
            8'hD9:       k = K_LONG_CALL;
            8'hDC:       k = K_REL;
            8'hDD:       k = K_IDX;
            8'hDE:       k = K_IND;
            8'hDF:       k = K_CMP_ACC;
            8'b11100???: k = K_FLAG;
            default:     k = K_SEQ;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DW-1:0]     test_reg,
    input  logic [DW-1:0]     acc,
    input  logic [DW-1:0]     cmp_imm,
    output logic              flag_hit,
    output logic              loop_hit,
    output logic              cmp_reg_hit,
    output logic              cmp_acc_hit
);
    // Condition pairs in opcode order; the low select bit inverts the sense.
    logic [FLAG_W-1:0] ordered;
    logic [DW-1:0]     dec_val;

    always_comb begin
        ordered     = {flags[FL_S], flags[FL_P], flags[FL_CY], flags[FL_Z]};
        flag_hit    = ordered[sel[SEL_W-1:1]] ^ sel[0];
        dec_val     = test_reg - DW'(1);
        loop_hit    = (dec_val != '0);
        cmp_reg_hit = (test_reg != cmp_imm);
        cmp_acc_hit = (acc != cmp_imm);
    end

endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [PC_W-1:0]  pc_seq,
    input  logic [SEL_W-1:0] op_lo,
    input  logic [DW-1:0]    op_byte,
    input  logic [DW-1:0]    acc,
    input  logic [PC_W-1:0]  dptr,
    output logic [PC_W-1:0]  page_tgt,
    output logic [PC_W-1:0]  rel_tgt,
    output logic [PC_W-1:0]  idx_tgt
);
    localparam int EXT_W = PC_W - DW;

    logic [PC_W-1:0] offs_sx;
    logic [PC_W-1:0] acc_zx;

    always_comb begin
        offs_sx  = {{EXT_W{op_byte[DW-1]}}, op_byte};
        acc_zx   = {{EXT_W{1'b0}}, acc};
        page_tgt = {pc_seq[PC_W-1:PAGE_LSB], op_lo, op_byte};
        rel_tgt  = pc_seq + offs_sx;
        idx_tgt  = dptr + acc_zx;
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic [PC_W-1:0]   pc_seq,
    input  logic [DW-1:0]     op_byte,
    input  logic [PC_W-1:0]   op_word,
    input  logic [DW-1:0]     acc,
    input  logic [PC_W-1:0]   dptr,
    input  logic [FLAG_W-1:0] flags,
    input  logic [DW-1:0]     test_reg,
    input  logic [DW-1:0]     cmp_imm,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic              is_call
);
    kind_e           kind;
    logic            flag_hit, loop_hit, cmp_reg_hit, cmp_acc_hit;
    logic [PC_W-1:0] page_tgt, rel_tgt, idx_tgt;
    npc_out_t        state_d, state_q;
    logic            armed_d, armed_q;

    npc_cond u_cond (
        .flags       (flags),
        .sel         (opcode[SEL_W-1:0]),
        .test_reg    (test_reg),
        .acc         (acc),
        .cmp_imm     (cmp_imm),
        .flag_hit    (flag_hit),
        .loop_hit    (loop_hit),
        .cmp_reg_hit (cmp_reg_hit),
        .cmp_acc_hit (cmp_acc_hit)
    );

    npc_target u_target (
        .pc_seq   (pc_seq),
        .op_lo    (opcode[SEL_W-1:0]),
        .op_byte  (op_byte),
        .acc      (acc),
        .dptr     (dptr),
        .page_tgt (page_tgt),
        .rel_tgt  (rel_tgt),
        .idx_tgt  (idx_tgt)
    );

    always_comb begin
        kind          = classify(opcode);
        state_d.pc    = pc_seq;
        state_d.taken = 1'b0;
        state_d.call  = 1'b0;
        armed_d       = 1'b1;
        unique case (kind)
            K_PAGE_JMP, K_PAGE_CALL: begin
                state_d.pc    = page_tgt;
                state_d.taken = 1'b1;
                state_d.call  = (kind == K_PAGE_CALL);
            end
            K_LONG_JMP, K_LONG_CALL: begin
                state_d.pc    = op_word;
                state_d.taken = 1'b1;
                state_d.call  = (kind == K_LONG_CALL);
            end
            K_REL: begin
                state_d.pc    = rel_tgt;
                state_d.taken = 1'b1;
            end
            K_IDX: begin
                state_d.pc    = idx_tgt;
                state_d.taken = 1'b1;
            end
            K_IND: begin
                state_d.pc    = dptr;
                state_d.taken = 1'b1;
            end
            K_FLAG, K_LOOP, K_CMP_REG, K_CMP_ACC: begin
                state_d.taken = (kind == K_FLAG    && flag_hit)
                             || (kind == K_LOOP    && loop_hit)
                             || (kind == K_CMP_REG && cmp_reg_hit)
                             || (kind == K_CMP_ACC && cmp_acc_hit);
                if (state_d.taken) state_d.pc = rel_tgt;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
        end
    end

    assign next_pc = state_q.pc;
    assign taken   = state_q.taken;
    assign is_call = state_q.call;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (next_pc == '0 && !taken && !is_call));

    // R12
    call_needs_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_call |-> taken);

    // R11
    fallthrough_seq_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !taken |-> next_pc == $past(pc_seq));

    // R3
    page_fields_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(opcode[OP_W-1:SEL_W]) == 5'b11000)
        |-> (next_pc[PC_W-1:PAGE_LSB] == $past(pc_seq[PC_W-1:PAGE_LSB])
             && next_pc[PAGE_LSB-1:DW] == $past(opcode[SEL_W-1:0])
             && taken && !is_call));

    // R9
    loop_one_falls_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(opcode[OP_W-1:2]) == 6'b110100 && $past(test_reg) == 8'h01) |-> !taken);

endmodule

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] pc_seq = '0;
    logic [7:0]  op_byte = '0;
    logic [15:0] op_word = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic [3:0]  flags = '0;
    logic [7:0]  test_reg = '0;
    logic [7:0]  cmp_imm = '0;
    logic [15:0] next_pc;
    logic        taken;
    logic        is_call;

    int n_vec  = 0;
    int n_fail = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    npc_unit i_npc_unit (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .pc_seq(pc_seq),
        .op_byte(op_byte), .op_word(op_word), .acc(acc), .dptr(dptr),
        .flags(flags), .test_reg(test_reg), .cmp_imm(cmp_imm),
        .next_pc(next_pc), .taken(taken), .is_call(is_call)
    );

    function automatic string tag_of(input logic [7:0] op);
        if (op >= 8'hC0 && op <= 8'hC7) return "R3";
        if (op >= 8'hC8 && op <= 8'hCF) return "R4 R12";
        if (op == 8'hD8 || op == 8'hD9) return "R5 R12";
        if (op == 8'hDC) return "R6";
        if (op == 8'hDD || op == 8'hDE) return "R7";
        if (op >= 8'hE0 && op <= 8'hE7) return "R8 R11";
        if (op >= 8'hD0 && op <= 8'hD3) return "R9 R11";
        if ((op >= 8'hD4 && op <= 8'hD7) || op == 8'hDF) return "R10 R11";
        return "R11";
    endfunction

    // Apply one vector, let it register, check on the following falling edge (R2).
    task automatic apply_check();
        logic [15:0] e_pc;
        logic        e_t, e_c, cond;
        logic [15:0] rel;
        logic [7:0]  d;
        rel  = pc_seq + {{8{op_byte[7]}}, op_byte};
        e_pc = pc_seq; e_t = 1'b0; e_c = 1'b0; cond = 1'b0;
        if (opcode >= 8'hC0 && opcode <= 8'hCF) begin
            e_pc = {pc_seq[15:11], opcode[2:0], op_byte};
            e_t = 1'b1; e_c = opcode[3];
        end else if (opcode == 8'hD8 || opcode == 8'hD9) begin
            e_pc = op_word; e_t = 1'b1; e_c = (opcode == 8'hD9);
        end else if (opcode == 8'hDC) begin
            e_pc = rel; e_t = 1'b1;
        end else if (opcode == 8'hDD) begin
            e_pc = dptr + 16'(acc); e_t = 1'b1;
        end else if (opcode == 8'hDE) begin
            e_pc = dptr; e_t = 1'b1;
        end else begin
            if (opcode >= 8'hD0 && opcode <= 8'hD3) begin
                d = test_reg - 8'd1; cond = (d != 8'd0);
            end else if (opcode >= 8'hD4 && opcode <= 8'hD7) begin
                cond = (test_reg != cmp_imm);
            end else if (opcode == 8'hDF) begin
                cond = (acc != cmp_imm);
            end else if (opcode >= 8'hE0 && opcode <= 8'hE7) begin
                case (opcode[2:0])
                    3'd0: cond = flags[1];
                    3'd1: cond = !flags[1];
                    3'd2: cond = flags[0];
                    3'd3: cond = !flags[0];
                    3'd4: cond = flags[2];
                    3'd5: cond = !flags[2];
                    3'd6: cond = flags[3];
                    default: cond = !flags[3];
                endcase
            end
            if (cond) begin e_pc = rel; e_t = 1'b1; end
        end
        @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (next_pc !== e_pc || taken !== e_t || is_call !== e_c) begin
            n_fail++;
            $display("FAIL %s (R2) op=%02h: got pc=%04h t=%0b c=%0b, expected pc=%04h t=%0b c=%0b",
                     tag_of(opcode), opcode, next_pc, taken, is_call, e_pc, e_t, e_c);
        end
    endtask

    task automatic scramble();
        seed = seed * 32'd1664525 + 32'd1013904223; pc_seq  = seed[31:16];
        seed = seed * 32'd1664525 + 32'd1013904223; op_word = seed[31:16];
        seed = seed * 32'd1664525 + 32'd1013904223; dptr    = seed[31:16];
        seed = seed * 32'd1664525 + 32'd1013904223;
        op_byte = seed[31:24]; acc = seed[23:16]; flags = seed[11:8];
        seed = seed * 32'd1664525 + 32'd1013904223;
        test_reg = seed[31:24]; cmp_imm = seed[23:16];
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        opcode = 8'hD8; op_word = 16'hBEEF;
        repeat (3) @(negedge clk);
        n_vec++;
        // R1: outputs cleared while reset is held
        if (next_pc !== 16'h0 || taken !== 1'b0 || is_call !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset: got pc=%04h t=%0b c=%0b, expected pc=0000 t=0 c=0",
                     next_pc, taken, is_call);
        end
        rst_n = 1'b1;

        // All opcodes under several operand patterns; some force compare equality (R10).
        for (int p = 0; p < 8; p++) begin
            for (int op = 0; op < 256; op++) begin
                @(negedge clk);
                scramble();
                if (p % 2 == 1) cmp_imm = test_reg;
                if (p % 4 == 2) acc = cmp_imm;
                if (p == 3) op_byte = 8'h80;
                if (p == 5) begin dptr = 16'hFFFF; acc = 8'h02; end
                opcode = 8'(op);
                apply_check();
            end
        end

        // R8: every flag combination for every flag condition
        for (int op = 8'hE0; op <= 8'hE7; op++) begin
            for (int f = 0; f < 16; f++) begin
                @(negedge clk);
                scramble();
                opcode = 8'(op); flags = 4'(f);
                apply_check();
            end
        end

        // R9: every register value for every loop opcode, including 0x00 and 0x01
        for (int op = 8'hD0; op <= 8'hD3; op++) begin
            for (int r = 0; r < 256; r++) begin
                @(negedge clk);
                scramble();
                opcode = 8'(op); test_reg = 8'(r);
                apply_check();
            end
        end

        // R6: wraparound of the relative target at both ends
        @(negedge clk); scramble(); opcode = 8'hDC; pc_seq = 16'hFFF0; op_byte = 8'h20; apply_check();
        @(negedge clk); scramble(); opcode = 8'hDC; pc_seq = 16'h0005; op_byte = 8'hF0; apply_check();

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule